// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a 16-bit signal processor. It keeps two 16-bit multiplicand registers (X and Y), a 32-bit product that always follows them, and a 32-bit accumulator. The accumulator is read out as a high word and a low word. Each clock cycle the block carries out one operation, chosen by a 4-bit operation code. The caller supplies the operand words directly. Fetching operands from memory and decoding instructions happen outside this block.

The product is signed. Whenever it enters the accumulator it is doubled, which keeps the binary point in the right place for Q15 fractional data. Single-word add and subtract touch only the high accumulator word. The fused multiply-add and multiply-subtract operations do two things in one cycle: they fold the product of the current multiplicands into the accumulator and latch a new pair of multiplicands. This lets a dot-product loop issue one operation per term.

There is no sequencing state. The single controlling register is the accumulator, and its next value is chosen each cycle by a unique case over the operation code.

Top module: `mac_dp`

## Requirements
- R1: While `rst_n` is low, X, Y and the accumulator are all zero.
- R2: `prod_o` always equals the signed two's-complement product of the X and Y registers, 32 bits wide. No operation writes it directly. It follows a change to X or Y in the same cycle those registers change.
- R3: Operation code 1 loads X from `opa_i` and code 2 loads Y from `opb_i`. The other multiplicand and the accumulator are left unchanged.
- R4: Operation code 3 loads X from `opa_i` and Y from `opb_i` in the same cycle, leaving the accumulator unchanged.
- R5: Operation code 4 loads the accumulator with the product shifted left by one bit, truncated to 32 bits. The high 16 bits go to `acc_hi_o` and the low 16 bits to `acc_lo_o`.
- R6: Operation code 5 adds the product shifted left by one bit to the full 32-bit accumulator, modulo 2^32.
- R7: Operation code 6 adds `opa_i` to the high accumulator word and code 7 subtracts `opa_i` from it, both modulo 2^16. The low word is left unchanged.
- R8: Operation code 8 shifts the 32-bit accumulator left by one bit, filling with zero. Code 9 shifts it right by one bit, copying the sign bit.
- R9: Operation code 10 clears the 32-bit accumulator and loads X from `opa_i` and Y from `opb_i`.
- R10: Operation code 11 adds, and code 12 subtracts, the doubled product of the multiplicands held before the operation to or from the 32-bit accumulator. In the same cycle X is loaded from `opa_i` and Y from `opb_i`.
- R11: Operation code 0 and codes 13 to 15 leave X, Y and the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| opa_i | input | 16 | Operand for X, or addend for the high word |
| opb_i | input | 16 | Operand for Y |
| x_o | output | 16 | Multiplicand register X |
| y_o | output | 16 | Multiplicand register Y |
| prod_o | output | 32 | Signed product of X and Y |
| acc_hi_o | output | 16 | High accumulator word |
| acc_lo_o | output | 16 | Low accumulator word |

## Verification
The hardest situation to reach is a fused multiply-add or multiply-subtract whose result shows whether the old or the new multiplicands were used. The stimulus first loads a negative multiplicand pair. It then issues a multiply-add with a very different new pair, followed by a multiply-subtract with zeros. Only the old product accounts for the accumulator values that follow. Boundary cases are driven the same way. Two fractional minus-ones make a doubled product that wraps the accumulator to zero on a second add. The largest positive value times minus one carries across the word boundary. Subtracting from the high word borrows without disturbing the low word.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LDX  = 4'd1,
        OP_LDY  = 4'd2,
        OP_LDXY = 4'd3,
        OP_LDP  = 4'd4,
        OP_ADDP = 4'd5,
        OP_ADDH = 4'd6,
        OP_SUBH = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_MLD  = 4'd10,
        OP_MADD = 4'd11,
        OP_MSUB = 4'd12
    } mac_op_e;
endpackage

// File: rtl/mac_operand_regs.sv
module mac_operand_regs #(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mac_pkg::mac_op_e op,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    output logic [W-1:0]     x_q,
    output logic [W-1:0]     y_q
);
    import mac_pkg::*;

    logic load_x, load_y;

    always_comb begin
        load_x = 1'b0;
        load_y = 1'b0;
        unique case (op)
            OP_LDX:                     load_x = 1'b1;
            OP_LDY:                     load_y = 1'b1;
            OP_LDXY, OP_MLD,
            OP_MADD, OP_MSUB: begin
                load_x = 1'b1;
                load_y = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            if (load_x) x_q <= opa;
            if (load_y) y_q <= opb;
        end
    end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] x_ext, y_ext;

    // Sign-extend both factors so the low PW bits of the product are the signed result.
    assign x_ext = {{W{x[W-1]}}, x};
    assign y_ext = {{W{y[W-1]}}, y};
    assign prod  = x_ext * y_ext;
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mac_pkg::mac_op_e op,
    input  logic [W-1:0]     opa,
    input  logic [2*W-1:0]   prod,
    output logic [2*W-1:0]   acc_q
);
    import mac_pkg::*;

    localparam int AW = 2 * W;

    logic [AW-1:0] dbl;
    logic [AW-1:0] acc_d;
    logic [W-1:0]  hi_q, lo_q;

    assign dbl  = {prod[AW-2:0], 1'b0};
    assign hi_q = acc_q[AW-1:W];
    assign lo_q = acc_q[W-1:0];

    always_comb begin
        acc_d = acc_q;
        unique case (op)
            OP_LDP:          acc_d = dbl;
            OP_ADDP,
            OP_MADD:         acc_d = acc_q + dbl;
            OP_MSUB:         acc_d = acc_q - dbl;
            OP_ADDH:         acc_d = {hi_q + opa, lo_q};
            OP_SUBH:         acc_d = {hi_q - opa, lo_q};
            OP_SHL:          acc_d = {acc_q[AW-2:0], 1'b0};
            OP_SHR:          acc_d = {acc_q[AW-1], acc_q[AW-1:1]};
            OP_MLD:          acc_d = '0;
            default:         acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/mac_dp.sv
module mac_dp #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     op_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    output logic [W-1:0]   x_o,
    output logic [W-1:0]   y_o,
    output logic [2*W-1:0] prod_o,
    output logic [W-1:0]   acc_hi_o,
    output logic [W-1:0]   acc_lo_o
);
    import mac_pkg::*;

    localparam int AW = 2 * W;

    mac_op_e       op;
    logic [AW-1:0] acc;

    assign op = mac_op_e'(op_i);

    mac_operand_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .opa   (opa_i),
        .opb   (opb_i),
        .x_q   (x_o),
        .y_q   (y_o)
    );

    mac_mult #(.W(W)) u_mult (
        .x    (x_o),
        .y    (y_o),
        .prod (prod_o)
    );

    mac_accum #(.W(W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .opa   (opa_i),
        .prod  (prod_o),
        .acc_q (acc)
    );

    assign acc_hi_o = acc[AW-1:W];
    assign acc_lo_o = acc[W-1:0];
endmodule

// File: rtl/mac_dp_checker.sv
module mac_dp_checker #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     op_i,
    input logic [W-1:0]   opa_i,
    input logic [W-1:0]   opb_i,
    input logic [W-1:0]   x_o,
    input logic [W-1:0]   y_o,
    input logic [2*W-1:0] prod_o,
    input logic [W-1:0]   acc_hi_o,
    input logic [W-1:0]   acc_lo_o
);
    logic [2*W-1:0] acc;
    assign acc = {acc_hi_o, acc_lo_o};

    AST_LDX_KEEPS_Y: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1) |=> (y_o == $past(y_o) && x_o == $past(opa_i)));  // R3
    AST_LDXY_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3) |=> (x_o == $past(opa_i) && y_o == $past(opb_i) && $stable(acc)));  // R4
    AST_LDP_DOUBLES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4) |=> (acc == {$past(prod_o[2*W-2:0]), 1'b0}));  // R5
    AST_ADDP_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5) |=> (acc == $past(acc) + {$past(prod_o[2*W-2:0]), 1'b0}));  // R6
    AST_HALF_ADD_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd6 || op_i == 4'd7) |=> $stable(acc_lo_o));  // R7
    AST_SHR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9) |=> (acc_hi_o[W-1] == $past(acc_hi_o[W-1])));  // R8
    AST_MLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10) |=> (acc == '0));  // R9
    AST_MSUB_OLD_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd12) |=> (acc == $past(acc) - {$past(prod_o[2*W-2:0]), 1'b0}));  // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i > 4'd12) |=> ($stable(acc) && $stable(x_o) && $stable(y_o)));  // R11
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (acc == '0 && x_o == '0 && y_o == '0));  // R1
endmodule

bind mac_dp mac_dp_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .x_o      (x_o),
    .y_o      (y_o),
    .prod_o   (prod_o),
    .acc_hi_o (acc_hi_o),
    .acc_lo_o (acc_lo_o)
);

// File: tb/mac_dp_bench.sv
module mac_dp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [15:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic [15:0] x_o, y_o, acc_hi_o, acc_lo_o;
    logic [31:0] prod_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mac_dp u_mac_dp (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .x_o(x_o), .y_o(y_o), .prod_o(prod_o), .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] ex;
        logic [15:0] ey;
        logic [31:0] ep;
        logic [31:0] eacc;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{4'd1,  16'h0003, 16'h0000, 16'h0003, 16'h0000, 32'h00000000, 32'h00000000, 8'd3},
        '{4'd2,  16'h0000, 16'h0005, 16'h0003, 16'h0005, 32'h0000000F, 32'h00000000, 8'd3},
        '{4'd4,  16'h0000, 16'h0000, 16'h0003, 16'h0005, 32'h0000000F, 32'h0000001E, 8'd5},
        '{4'd5,  16'h0000, 16'h0000, 16'h0003, 16'h0005, 32'h0000000F, 32'h0000003C, 8'd6},
        '{4'd6,  16'h0002, 16'h0000, 16'h0003, 16'h0005, 32'h0000000F, 32'h0002003C, 8'd7},
        '{4'd7,  16'h0003, 16'h0000, 16'h0003, 16'h0005, 32'h0000000F, 32'hFFFF003C, 8'd7},
        '{4'd9,  16'h0000, 16'h0000, 16'h0003, 16'h0005, 32'h0000000F, 32'hFFFF801E, 8'd8},
        '{4'd8,  16'h0000, 16'h0000, 16'h0003, 16'h0005, 32'h0000000F, 32'hFFFF003C, 8'd8},
        '{4'd3,  16'hFFFE, 16'h0007, 16'hFFFE, 16'h0007, 32'hFFFFFFF2, 32'hFFFF003C, 8'd4},
        '{4'd11, 16'h0004, 16'h4000, 16'h0004, 16'h4000, 32'h00010000, 32'hFFFF0020, 8'd10},
        '{4'd12, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 32'h00000000, 32'hFFFD0020, 8'd10},
        '{4'd0,  16'h0009, 16'h0009, 16'h0000, 16'h0000, 32'h00000000, 32'hFFFD0020, 8'd11},
        '{4'd14, 16'h0009, 16'h0009, 16'h0000, 16'h0000, 32'h00000000, 32'hFFFD0020, 8'd11},
        '{4'd10, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 32'h40000000, 32'h00000000, 8'd9},
        '{4'd4,  16'h0000, 16'h0000, 16'h8000, 16'h8000, 32'h40000000, 32'h80000000, 8'd5},
        '{4'd5,  16'h0000, 16'h0000, 16'h8000, 16'h8000, 32'h40000000, 32'h00000000, 8'd6},
        '{4'd1,  16'h7FFF, 16'h0000, 16'h7FFF, 16'h8000, 32'hC0008000, 32'h00000000, 8'd2},
        '{4'd4,  16'h0000, 16'h0000, 16'h7FFF, 16'h8000, 32'hC0008000, 32'h80010000, 8'd5},
        '{4'd6,  16'h8000, 16'h0000, 16'h7FFF, 16'h8000, 32'hC0008000, 32'h00010000, 8'd7}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b;
        @(posedge clk);
        #1;
    endtask

    task automatic check_all(input string req, input logic [15:0] ex, input logic [15:0] ey,
                             input logic [31:0] ep, input logic [31:0] eacc);
        check(req, "x", {16'h0, x_o}, {16'h0, ex});
        check(req, "y", {16'h0, y_o}, {16'h0, ey});
        check(req, "prod", prod_o, ep);
        check(req, "acc", {acc_hi_o, acc_lo_o}, eacc);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: state during reset
        repeat (3) @(posedge clk);
        #1;
        check_all("1", 16'h0, 16'h0, 32'h0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector walk covering R2 to R11
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].op, TBL[i].a, TBL[i].b);
            check($sformatf("%0d", TBL[i].req), $sformatf("vec%0d", i), 32'h0, 32'h0);
            check_all($sformatf("%0d", TBL[i].req), TBL[i].ex, TBL[i].ey, TBL[i].ep, TBL[i].eacc);
        end

        // R2: product follows a fresh load of both factors in the same cycle
        step(4'd3, 16'hFFFF, 16'hFFFF);
        check("2", "prod min1*min1", prod_o, 32'h00000001);

        // R8: shift left drops the top bit and fills with zero
        step(4'd4, 16'h0, 16'h0);
        step(4'd9, 16'h0, 16'h0);
        check("8", "shr positive", {acc_hi_o, acc_lo_o}, 32'h00000001);
        step(4'd8, 16'h0, 16'h0);
        step(4'd8, 16'h0, 16'h0);
        check("8", "shl twice", {acc_hi_o, acc_lo_o}, 32'h00000004);

        // R11: highest unused code leaves everything unchanged
        step(4'd15, 16'h1234, 16'h5678);
        check_all("11", 16'hFFFF, 16'hFFFF, 32'h00000001, 32'h00000004);

        // R1: reset in the middle of operation clears everything
        @(negedge clk);
        op_i = 4'd0;
        rst_n = 1'b0;
        #2;
        check_all("1", 16'h0, 16'h0, 32'h0, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule